// File: doc/BRIEF.md
# Banked DRAM Row-Buffer Array

This block is a cycle-level model of a small multi-bank dynamic memory array with its access controller in front. A request carries one flat address, a write flag and a write word. The address is cut into a bank, a row and a column. Each bank holds one row buffer. Opening a row drains the whole row out of the cell array into that bank's buffer. Every read or write then works on the buffer, never on the array. Before a bank opens a different row, the buffer is stored back into the row it came from.

A request to a row that is already open in its bank takes a single cycle. A request to any other row pays a fixed row cycle: store back, fetch, fill, and then the access. Banks keep their open rows independently of each other.

A free-running timer asks for refresh at a fixed interval. The controller finishes the access in flight and then stops taking requests. It closes every open row with a store-back, then reads and restores one row index in all banks at once. The next refresh moves on to the next row index, so repeated refreshes sweep every row.

Top module: `bank_rowbuf_dram`

## Requirements
- R1: The address is `{bank, row, column}`: the column takes the low log2(COLS) bits, the row the next log2(ROWS) bits, and the bank the top log2(NUM_BANKS) bits. Words that differ in any single field are stored apart.
- R2: After reset `req_ready` is 1, `rsp_valid` is 0 and no bank has an open row, so the first access to every bank is a miss.
- R3: A request to a row that is not open in its bank raises `rsp_valid` MISS_CYC+1 cycles after the accepting clock edge. `req_ready` stays 0 during that time, and no response appears in the cycle after acceptance.
- R4: A request to the row open in its bank raises `rsp_valid` in the cycle right after the accepting edge, and `req_ready` stays 1, so hits can be issued back to back.
- R5: A read returns the last word written to the same address. A write replaces only the selected column word of the open row.
- R6: Opening a different row in a bank first stores the buffer back into its own row, so the data in the old row survives when the bank moves to another row and later returns.
- R7: Each bank keeps its own open row. An access to one bank does not close the row open in another bank.
- R8: A refresh request is raised every REF_PERIOD cycles. The access in flight completes, no request is accepted until the refresh ends, and afterwards no row is open, so the next access is a miss. All stored data is preserved.
- R9: `rsp_valid` is high for exactly one cycle per accepted request, and responses come back in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | Bank, row and column fields |
| req_wdata | input | DW | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word; valid with `rsp_valid` for reads |

## Verification
The stimulus starts from an empty array and opens rows with writes. Runs of same-row accesses then separate the hit timing from the miss timing. Accesses that alternate between two banks show that each bank keeps its own open row. Alternating two rows inside one bank shows that store-back keeps the old row's data. Addresses that differ in only one field confirm the field split. The bench lets refresh fire between and during these runs. A bank that was open before a refresh must then take the miss latency and still return its old data.

// File: rtl/dram_rb_pkg.sv
package dram_rb_pkg;
  // Operation presented to a bank for one clock cycle
  typedef enum logic [2:0] {
    BK_NOP,
    BK_WB,       // store open line back into its row, close it
    BK_FETCH,    // read a row out of the cell array into the fetch register
    BK_FILL,     // move fetched row into the line buffer, mark it open
    BK_RD,       // copy one column word out of the line buffer
    BK_WR,       // overwrite one column word in the line buffer
    BK_RESTORE   // write the fetched row back (refresh)
  } bank_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_REF_WB,
    ST_REF_FETCH,
    ST_REF_RESTORE
  } ctrl_state_e;
endpackage

// File: rtl/dram_rb_bank.sv
module dram_rb_bank
  import dram_rb_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int DW   = 16,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int LINE_W = COLS * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  bank_op_e         op,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [DW-1:0]    wdata,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic [DW-1:0]    rdata_o
);
  logic [LINE_W-1:0] cells [ROWS];
  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] fetch_q;
  logic              open_q;
  logic [ROW_W-1:0]  open_row_q;
  logic [DW-1:0]     rdata_q;

  logic              cell_we;
  logic [ROW_W-1:0]  cell_waddr;
  logic [LINE_W-1:0] cell_wdata;

  always_comb begin
    cell_we    = en && ((op == BK_WB && open_q) || op == BK_RESTORE);
    cell_waddr = (op == BK_WB) ? open_row_q : row;
    cell_wdata = (op == BK_WB) ? line_q : fetch_q;
  end

  // Simple dual-port array: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (cell_we) cells[cell_waddr] <= cell_wdata;
    if (en && op == BK_FETCH) fetch_q <= cells[row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q     <= 1'b0;
      open_row_q <= '0;
    end else if (en) begin
      if (op == BK_WB) open_q <= 1'b0;
      if (op == BK_FILL) begin
        open_q     <= 1'b1;
        open_row_q <= row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      case (op)
        BK_FILL: line_q <= fetch_q;
        BK_RD:   rdata_q <= line_q[DW*int'(col) +: DW];
        BK_WR:   line_q[DW*int'(col) +: DW] <= wdata;
        default: ;
      endcase
    end
  end

  assign open_o     = open_q;
  assign open_row_o = open_row_q;
  assign rdata_o    = rdata_q;

  // R6: a row is only fetched once the previous line has been stored back
  p_fetch_after_close_r6: assert property (@(posedge clk) disable iff (rst)
    (en && op == BK_FETCH) |-> !open_q);

  // R5: column accesses only ever touch an open line
  p_access_needs_open_r5: assert property (@(posedge clk) disable iff (rst)
    (en && (op == BK_RD || op == BK_WR)) |-> open_q);
endmodule

// File: rtl/dram_rb_refresh_timer.sv
module dram_rb_refresh_timer #(
  parameter int PERIOD = 256,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  output logic pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             tick;

  assign tick = (cnt_q == CNT_W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)      pend_q <= 1'b1;
      else if (done) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R8: the controller only finishes a refresh that was requested
  p_done_only_when_pending_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> pend_q);

  // R8: the interval expiring always leaves a request pending
  p_tick_raises_request_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> pend_q);
endmodule

// File: rtl/bank_rowbuf_dram.sv
module bank_rowbuf_dram
  import dram_rb_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int ROWS       = 16,
  parameter int COLS       = 8,
  parameter int DW         = 16,
  parameter int MISS_CYC   = 4,
  parameter int REF_PERIOD = 256,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int CNT_W  = $clog2(MISS_CYC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_CYC - 1);

  ctrl_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BANK_W-1:0] lat_bank_q, rsp_bank_q;
  logic [ROW_W-1:0]  lat_row_q, ref_row_q;
  logic [COL_W-1:0]  lat_col_q;
  logic              lat_we_q;
  logic [DW-1:0]     lat_wdata_q;
  logic              rsp_valid_q;

  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              accept, hit, ref_pend, ref_done;

  bank_op_e          op;
  logic              bcast;
  logic [BANK_W-1:0] tgt_bank;
  logic [ROW_W-1:0]  bk_row;
  logic [COL_W-1:0]  bk_col;
  logic [DW-1:0]     bk_wdata;

  logic              bank_en   [NUM_BANKS];
  logic              bank_open [NUM_BANKS];
  logic [ROW_W-1:0]  bank_orow [NUM_BANKS];
  logic [DW-1:0]     bank_rd   [NUM_BANKS];

  assign req_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign req_row  = req_addr[COL_W +: ROW_W];
  assign req_col  = req_addr[COL_W-1:0];

  assign req_ready = (state_q == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign hit       = bank_open[req_bank] && (bank_orow[req_bank] == req_row);
  assign ref_done  = (state_q == ST_REF_RESTORE);

  dram_rb_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .done   (ref_done),
    .pend_o (ref_pend)
  );

  // Bank operation for this cycle
  always_comb begin
    op       = BK_NOP;
    bcast    = 1'b0;
    tgt_bank = lat_bank_q;
    bk_row   = lat_row_q;
    bk_col   = lat_col_q;
    bk_wdata = lat_wdata_q;
    case (state_q)
      ST_IDLE: if (accept && hit) begin
        op       = req_we ? BK_WR : BK_RD;
        tgt_bank = req_bank;
        bk_row   = req_row;
        bk_col   = req_col;
        bk_wdata = req_wdata;
      end
      ST_ROW: begin
        if      (cnt_q == CNT_W'(0)) op = BK_WB;
        else if (cnt_q == CNT_W'(1)) op = BK_FETCH;
        else if (cnt_q == CNT_W'(2)) op = BK_FILL;
        else if (cnt_q == LAST)      op = lat_we_q ? BK_WR : BK_RD;
      end
      ST_REF_WB: begin
        op    = BK_WB;
        bcast = 1'b1;
      end
      ST_REF_FETCH: begin
        op     = BK_FETCH;
        bcast  = 1'b1;
        bk_row = ref_row_q;
      end
      ST_REF_RESTORE: begin
        op     = BK_RESTORE;
        bcast  = 1'b1;
        bk_row = ref_row_q;
      end
      default: ;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_en[b] = bcast || (op != BK_NOP && tgt_bank == BANK_W'(b));
    dram_rb_bank #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .en         (bank_en[b]),
      .op         (op),
      .row        (bk_row),
      .col        (bk_col),
      .wdata      (bk_wdata),
      .open_o     (bank_open[b]),
      .open_row_o (bank_orow[b]),
      .rdata_o    (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_bank_q  <= '0;
      ref_row_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ref_pend) state_q <= ST_REF_WB;
          else if (accept) begin
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_bank_q  <= req_bank;
            end else begin
              state_q <= ST_ROW;
              cnt_q   <= '0;
            end
          end
        end
        ST_ROW: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            cnt_q       <= '0;
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_bank_q  <= lat_bank_q;
          end
        end
        ST_REF_WB:    state_q <= ST_REF_FETCH;
        ST_REF_FETCH: state_q <= ST_REF_RESTORE;
        ST_REF_RESTORE: begin
          state_q   <= ST_IDLE;
          ref_row_q <= ref_row_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      lat_bank_q  <= req_bank;
      lat_row_q   <= req_row;
      lat_col_q   <= req_col;
      lat_we_q    <= req_we;
      lat_wdata_q <= req_wdata;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = bank_rd[rsp_bank_q];

  // R4: an open-row hit completes in the very next cycle
  p_hit_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |=> rsp_valid);

  // R3: a miss never answers in the cycle after acceptance
  p_miss_no_early_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> !rsp_valid);

  // R9: every response traces back to a hit acceptance or a finishing row cycle
  p_rsp_has_source_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(accept && hit) || $past(state_q == ST_ROW)));
endmodule

// File: tb/tb_bank_rowbuf_dram.sv
module tb_bank_rowbuf_dram;
  localparam int NB = 2, NR = 8, NC = 4, DW = 16, MISS = 4, RP = 100;
  localparam int BW = 1, RW = 3, CW = 2, AW = BW + RW + CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;

  always #10 clk = ~clk;

  bank_rowbuf_dram #(.NUM_BANKS(NB), .ROWS(NR), .COLS(NC), .DW(DW),
                     .MISS_CYC(MISS), .REF_PERIOD(RP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  typedef struct {
    logic          rd;
    logic [DW-1:0] data;
    int            lat;
    int            acc;
    string         req;
  } item_t;

  item_t         sb[$];
  int            cyc = 0;
  int            n_chk = 0, n_fail = 0, n_ref = 0;
  bit            in_ref = 0;
  bit            m_open [NB];
  int            m_row  [NB];
  logic [DW-1:0] shadow [1 << AW];

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Driver: waits for ready, predicts the outcome and pushes it to the scoreboard
  task automatic issue(bit we, int bank, int row, int col, logic [DW-1:0] d, string req);
    item_t it;
    int a;
    bit h;
    while (!req_ready) @(negedge clk);
    a = (bank << (RW + CW)) | (row << CW) | col;
    h = m_open[bank] && (m_row[bank] == row);
    it.rd  = !we;
    it.lat = h ? 1 : MISS + 1;
    it.acc = cyc;
    it.req = req;
    if (we) begin
      shadow[a] = d;
      it.data = d;
    end else it.data = shadow[a];
    m_open[bank] = 1;
    m_row[bank]  = row;
    sb.push_back(it);
    req_we    = we;
    req_addr  = AW'(a);
    req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) check(0, "R9", "unexpected response", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(cyc - it.acc == it.lat, it.req, "latency", cyc - it.acc, it.lat);
        if (it.rd) check(rsp_rdata == it.data, it.req, "read data", rsp_rdata, it.data);
      end
    end
  end

  // Refresh observer: ready low with nothing outstanding means refresh is running
  always @(negedge clk) begin
    if (!rst) begin
      if (!req_ready && sb.size() == 0) begin
        if (!in_ref) begin
          in_ref = 1;
          n_ref++;
          for (int b = 0; b < NB; b++) m_open[b] = 0;
        end
      end else if (req_ready) in_ref = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    int r0;
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check(req_ready == 1'b1, "R2", "req_ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R2", "rsp_valid after reset", rsp_valid, 0);

    // R2/R3: first access is a miss, ready drops during the row cycle
    issue(1, 0, 1, 0, 16'hA1A1, "R2 R3 first miss");
    check(req_ready == 1'b0, "R3", "req_ready during row cycle", req_ready, 0);
    // R4: hits back to back on the open row
    issue(1, 0, 1, 1, 16'hB2B2, "R4 hit write");
    issue(0, 0, 1, 0, 16'h0, "R4 R5 hit read");
    issue(0, 0, 1, 1, 16'h0, "R5 hit read col1");
    drain();

    // R7: second bank opens without closing the first
    issue(1, 1, 2, 3, 16'hC3C3, "R7 R2 bank1 first miss");
    issue(0, 0, 1, 1, 16'h0, "R7 bank0 still open");
    issue(0, 1, 2, 3, 16'h0, "R7 bank1 still open");
    drain();

    // R6: row switching inside one bank keeps old data
    issue(1, 0, 5, 0, 16'hD4D4, "R6 open other row");
    issue(0, 0, 1, 0, 16'h0, "R6 return to row1");
    issue(0, 0, 5, 0, 16'h0, "R6 return to row5");
    drain();

    // R1: addresses differing in one field only
    issue(1, 1, 1, 0, 16'hE5E5, "R1 bank differs");
    issue(1, 0, 1, 2, 16'hF6F6, "R1 column differs");
    issue(1, 0, 3, 0, 16'h1717, "R1 row differs");
    issue(0, 0, 1, 0, 16'h0, "R1 base word");
    issue(0, 1, 1, 0, 16'h0, "R1 bank word");
    issue(0, 0, 1, 2, 16'h0, "R1 column word");
    issue(0, 0, 3, 0, 16'h0, "R1 row word");
    drain();

    // R4/R5/R9: burst of hits over every column
    for (int k = 0; k < 8; k++) issue(1, 1, 6, k % NC, DW'(16'h3000 + k), "R4 R9 burst write");
    for (int k = 0; k < NC; k++) issue(0, 1, 6, k, 16'h0, "R5 R9 burst read");
    drain();

    // R8: after a refresh every open row is closed but data survives
    r0 = n_ref;
    issue(0, 1, 6, 2, 16'h0, "R8 open before refresh");
    while (n_ref == r0) @(negedge clk);
    check(n_ref > r0, "R8", "refresh observed", n_ref, r0 + 1);
    issue(0, 1, 6, 2, 16'h0, "R8 miss after refresh");
    issue(0, 0, 5, 0, 16'h0, "R8 data kept bank0");
    issue(0, 1, 2, 3, 16'h0, "R8 data kept bank1");
    drain();
    check(n_ref * RP <= cyc + RP, "R8", "refresh count bound", n_ref, cyc / RP);

    check(sb.size() == 0, "R9", "outstanding responses", sb.size(), 0);
    finish_run();
  end
endmodule